// File: doc/BRIEF.md
# Load-Source Pointer Selector

This block holds the pointer state of a small 16-bit microcontroller's data-memory addressing unit. It keeps four pointer registers (data pointer A, data pointer B, a 16-bit base and an 8-bit offset) and a control word. The control word picks which pointer drives the address for data loads, and holds a separate word/byte access mode for each of the three pointer sources. The frame source is the base plus the offset. The block presents the chosen address, its access width and a valid flag to the data-memory side.

Software reaches the registers through a register port with an address, write data, a write strobe and combinational read data. A second write path, the load-result port, lets the execution datapath write a pointer directly. Any pointer write, from either path, moves the select field so that it names the pointer just written.

The select field is a four-state machine with the states SEL_DP0, SEL_DP1, SEL_FP and SEL_FPX. It has three transitions. T_PTR jumps to the state of the pointer that was written. T_CTRL takes the state from the written select bits. T_HOLD stays in the current state. A second two-state machine has the states ARM_WAIT and ARM_LIVE. It makes data pointer A invalid as a source after reset until software arms it.

Top module: `dptr_sel_ctrl`

## Requirements
- R1: After reset the control word (register address 0) reads 0x001C. All pointers read 0, `src_valid` is 0, `src_word` is 1 and `src_addr` is 0.
- R2: Select code 00 in control bits [1:0] drives `src_addr` from data pointer A (address 1). Code 01 drives it from data pointer B (address 2). Code 10 drives it from the frame sum.
- R3: Select code 11 reads back as 11 and behaves exactly like code 10.
- R4: Control bit 2 sets the mode of pointer A, bit 3 the mode of pointer B and bit 4 the mode of the frame source, with 1 meaning word and 0 meaning byte. `src_word` shows the mode bit of the selected source.
- R5: Control bits [15:5] always read 0, whatever was written to them.
- R6: A write to pointer A sets the select code to 00. A write to pointer B sets it to 01. A write to the base (address 3) or the offset (address 4) sets it to 10.
- R7: While the select code is 00, `src_valid` stays 0 after reset until the select bits are written as 00 or pointer A is written. After that it stays 1 until the next reset. While the select code is not 00, `src_valid` is 1.
- R8: The frame address is the base plus the zero-extended offset, modulo 2^16.
- R9: When a control write and a pointer write fall in the same cycle, the select code follows the pointer write, and the mode bits take the written control values.
- R10: Read data is combinational from `reg_addr`. Writes take effect at the next rising edge. The offset reads back as its low byte, zero-extended. Addresses 5 to 7 read 0.
- R11: The load-result port targets pointers by `ld_dst`: 00 is A, 01 is B, 10 is the base and 11 is the offset. If it writes the same pointer as the register port in the same cycle, its data is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register select for read and write |
| reg_wdata | input | 16 | Register write data |
| reg_we | input | 1 | Register write strobe |
| reg_rdata | output | 16 | Combinational read data |
| ld_we | input | 1 | Load-result pointer write strobe |
| ld_dst | input | 2 | Load-result target pointer |
| ld_wdata | input | 16 | Load-result write data |
| src_addr | output | 16 | Address of the active load source |
| src_word | output | 1 | 1 = word access, 0 = byte access |
| src_valid | output | 1 | Active source may be used |

## Verification
The control-register write and a pointer write from the load-result port can land in the same edge. Both strobes are raised in one cycle: a control write that selects A with byte modes, paired with a load into pointer B. The result is judged by reading back a control word with select 01 and the written mode bits. A second collision drives both write paths at pointer A with different data, and the bench expects the load-result value to be kept.

// File: rtl/dptr_pkg.sv
`timescale 1ns/1ps
package dptr_pkg;
    typedef enum logic [1:0] {
        SEL_DP0 = 2'b00,
        SEL_DP1 = 2'b01,
        SEL_FP  = 2'b10,
        SEL_FPX = 2'b11
    } src_sel_e;

    typedef enum logic {
        ARM_WAIT = 1'b0,
        ARM_LIVE = 1'b1
    } arm_e;

    localparam int unsigned NPTR    = 4;
    localparam int unsigned PID_DP0 = 0;
    localparam int unsigned PID_DP1 = 1;
    localparam int unsigned PID_BP  = 2;
    localparam int unsigned PID_OFS = 3;

    localparam logic [2:0] RA_CTRL = 3'd0;
    localparam logic [2:0] RA_DP0  = 3'd1;
    localparam logic [2:0] RA_DP1  = 3'd2;
    localparam logic [2:0] RA_BP   = 3'd3;
    localparam logic [2:0] RA_OFS  = 3'd4;

    localparam logic [2:0] MODE_RST = 3'b111;
endpackage

// File: rtl/dptr_ptr_bank.sv
`timescale 1ns/1ps
module dptr_ptr_bank
    import dptr_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter int unsigned OW = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NPTR-1:0]     reg_hit,
    input  logic [DW-1:0]       reg_wdata,
    input  logic [NPTR-1:0]     ld_hit,
    input  logic [DW-1:0]       ld_wdata,
    output logic [NPTR-1:0][DW-1:0] ptr_q
);
    genvar gi;
    generate
        for (gi = 0; gi < NPTR; gi++) begin : g_ptr
            localparam int unsigned W = (gi == PID_OFS) ? OW : DW;
            logic [W-1:0] val_q;
            logic [W-1:0] val_d;

            always_comb begin
                val_d = val_q;
                if (ld_hit[gi])       val_d = ld_wdata[W-1:0];
                else if (reg_hit[gi]) val_d = reg_wdata[W-1:0];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) val_q <= '0;
                else        val_q <= val_d;
            end

            if (W < DW) begin : g_ext
                assign ptr_q[gi] = {{(DW-W){1'b0}}, val_q};
            end else begin : g_full
                assign ptr_q[gi] = val_q;
            end

            // R11: the load-result data is kept when both paths write this pointer
            p_ld_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
                ld_hit[gi] |=> val_q == $past(ld_wdata[W-1:0]));
        end
    endgenerate
endmodule

// File: rtl/dptr_ctrl.sv
`timescale 1ns/1ps
module dptr_ctrl
    import dptr_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ctrl_we,
    input  logic [DW-1:0]   ctrl_wdata,
    input  logic [NPTR-1:0] reg_hit,
    input  logic [NPTR-1:0] ld_hit,
    output src_sel_e        sel_q,
    output logic [2:0]      mode_q,
    output logic            armed
);
    typedef enum logic [1:0] {T_HOLD, T_CTRL, T_PTR} sel_tr_e;

    src_sel_e   sel_d;
    src_sel_e   ptr_code;
    sel_tr_e    tr;
    arm_e       arm_q, arm_d;
    logic [2:0] mode_d;
    logic [NPTR-1:0] lead;
    logic       any_ptr;
    logic       dp0_hit;

    // load-result path leads when both write paths are active
    assign lead    = (|ld_hit) ? ld_hit : reg_hit;
    assign any_ptr = |lead;
    assign dp0_hit = ld_hit[PID_DP0] | reg_hit[PID_DP0];

    always_comb begin
        ptr_code = SEL_FP;
        if (lead[PID_DP0])      ptr_code = SEL_DP0;
        else if (lead[PID_DP1]) ptr_code = SEL_DP1;
    end

    always_comb begin
        if (any_ptr)      tr = T_PTR;
        else if (ctrl_we) tr = T_CTRL;
        else              tr = T_HOLD;
    end

    always_comb begin
        sel_d = sel_q;
        unique case (tr)
            T_PTR:   sel_d = ptr_code;
            T_CTRL:  sel_d = src_sel_e'(ctrl_wdata[1:0]);
            T_HOLD:  sel_d = sel_q;
            default: sel_d = sel_q;
        endcase
    end

    always_comb begin
        arm_d = arm_q;
        unique case (arm_q)
            ARM_WAIT: if (dp0_hit || (tr == T_CTRL && ctrl_wdata[1:0] == 2'b00))
                          arm_d = ARM_LIVE;
            ARM_LIVE: arm_d = ARM_LIVE;
            default:  arm_d = arm_q;
        endcase
    end

    assign mode_d = ctrl_we ? ctrl_wdata[4:2] : mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q  <= SEL_DP0;
            arm_q  <= ARM_WAIT;
            mode_q <= MODE_RST;
        end else begin
            sel_q  <= sel_d;
            arm_q  <= arm_d;
            mode_q <= mode_d;
        end
    end

    assign armed = (arm_q == ARM_LIVE);

    // R6: a pointer A write selects A and arms it
    p_dp0_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dp0_hit |=> (sel_q == SEL_DP0) && armed);
    // R6: a lone pointer B write selects B
    p_dp1_sel_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_hit[PID_DP1] && !(|ld_hit)) |=> sel_q == SEL_DP1);
    // R7: once armed, stays armed until reset
    p_arm_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        armed |=> armed);
    // R4: modes only move on a control write
    p_mode_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_we |=> $stable(mode_q));
endmodule

// File: rtl/dptr_src_mux.sv
`timescale 1ns/1ps
module dptr_src_mux
    import dptr_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  src_sel_e                sel,
    input  logic [2:0]              mode,
    input  logic                    armed,
    input  logic [NPTR-1:0][DW-1:0] ptr,
    output logic [DW-1:0]           src_addr,
    output logic                    src_word,
    output logic                    src_valid
);
    logic [DW-1:0] fp_sum;

    assign fp_sum = ptr[PID_BP] + ptr[PID_OFS];

    always_comb begin
        src_addr  = fp_sum;
        src_word  = mode[2];
        src_valid = 1'b1;
        unique case (sel)
            SEL_DP0: begin
                src_addr  = ptr[PID_DP0];
                src_word  = mode[0];
                src_valid = armed;
            end
            SEL_DP1: begin
                src_addr = ptr[PID_DP1];
                src_word = mode[1];
            end
            SEL_FP, SEL_FPX: begin
                src_addr = fp_sum;
                src_word = mode[2];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/dptr_sel_ctrl.sv
`timescale 1ns/1ps
module dptr_sel_ctrl
    import dptr_pkg::*;
#(
    parameter int unsigned DW = 16,
    parameter int unsigned OW = 8,
    parameter int unsigned AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          reg_we,
    output logic [DW-1:0] reg_rdata,
    input  logic          ld_we,
    input  logic [1:0]    ld_dst,
    input  logic [DW-1:0] ld_wdata,
    output logic [DW-1:0] src_addr,
    output logic          src_word,
    output logic          src_valid
);
    localparam int unsigned RSV_W = DW - 5;

    logic [NPTR-1:0]         reg_hit;
    logic [NPTR-1:0]         ld_hit;
    logic                    ctrl_we;
    logic [NPTR-1:0][DW-1:0] ptr_q;
    src_sel_e                sel_q;
    logic [2:0]              mode_q;
    logic                    armed;

    assign ctrl_we = reg_we && (reg_addr == AW'(RA_CTRL));

    always_comb begin
        reg_hit = '0;
        if (reg_we) begin
            unique case (reg_addr)
                AW'(RA_DP0): reg_hit[PID_DP0] = 1'b1;
                AW'(RA_DP1): reg_hit[PID_DP1] = 1'b1;
                AW'(RA_BP):  reg_hit[PID_BP]  = 1'b1;
                AW'(RA_OFS): reg_hit[PID_OFS] = 1'b1;
                default: ;
            endcase
        end
    end

    assign ld_hit = ld_we ? (NPTR'(1) << ld_dst) : '0;

    dptr_ptr_bank #(.DW(DW), .OW(OW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_hit   (reg_hit),
        .reg_wdata (reg_wdata),
        .ld_hit    (ld_hit),
        .ld_wdata  (ld_wdata),
        .ptr_q     (ptr_q)
    );

    dptr_ctrl #(.DW(DW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (reg_wdata),
        .reg_hit    (reg_hit),
        .ld_hit     (ld_hit),
        .sel_q      (sel_q),
        .mode_q     (mode_q),
        .armed      (armed)
    );

    dptr_src_mux #(.DW(DW)) u_mux (
        .sel       (sel_q),
        .mode      (mode_q),
        .armed     (armed),
        .ptr       (ptr_q),
        .src_addr  (src_addr),
        .src_word  (src_word),
        .src_valid (src_valid)
    );

    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            AW'(RA_CTRL): reg_rdata = {{RSV_W{1'b0}}, mode_q, sel_q};
            AW'(RA_DP0):  reg_rdata = ptr_q[PID_DP0];
            AW'(RA_DP1):  reg_rdata = ptr_q[PID_DP1];
            AW'(RA_BP):   reg_rdata = ptr_q[PID_BP];
            AW'(RA_OFS):  reg_rdata = ptr_q[PID_OFS];
            default:      reg_rdata = '0;
        endcase
    end

    // R9: on a collision the modes follow the control write data
    p_collide_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_we && ld_we) |=> mode_q == $past(reg_wdata[4:2]));
    // R7: any non-A source is valid
    p_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q != SEL_DP0) |-> src_valid);
    // R3: the reserved code addresses the frame sum like code 10
    p_fpx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == SEL_FPX) |-> (src_word == mode_q[2]));
endmodule

// File: tb/sim_dptr_sel_ctrl.sv
`timescale 1ns/1ps
module sim_dptr_sel_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [15:0] reg_rdata;
    logic        ld_we = 1'b0;
    logic [1:0]  ld_dst = '0;
    logic [15:0] ld_wdata = '0;
    logic [15:0] src_addr;
    logic        src_word;
    logic        src_valid;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    dptr_sel_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata),
        .ld_we(ld_we), .ld_dst(ld_dst), .ld_wdata(ld_wdata),
        .src_addr(src_addr), .src_word(src_word), .src_valid(src_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; reg_we = 1'b0; ld_we = 1'b0; reg_addr = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one write cycle on either or both paths; returns one unit after the edge
    task automatic wr(input logic re, input logic [2:0] a, input logic [15:0] d,
                      input logic le, input logic [1:0] dst, input logic [15:0] ld);
        @(negedge clk);
        reg_we = re; reg_addr = a; reg_wdata = d;
        ld_we = le; ld_dst = dst; ld_wdata = ld;
        @(posedge clk);
        #1;
        reg_we = 1'b0; ld_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] v);
        reg_addr = a;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic t_reset();
        logic [15:0] v;
        do_reset();
        #1;
        rd(3'd0, v); chk("R1 ctrl", v, 16'h001C);
        for (int i = 1; i <= 4; i++) begin rd(3'(i), v); chk("R1 ptr", v, 16'h0); end
        chk("R1 valid", src_valid, 1'b0);
        chk("R1 word", src_word, 1'b1);
        chk("R1 addr", src_addr, 16'h0);
    endtask

    task automatic t_reserved_bits();
        logic [15:0] v;
        do_reset();
        wr(1, 3'd0, 16'hFFE1, 0, 2'd0, 16'h0);
        rd(3'd0, v); chk("R5 rsv zero", v, 16'h0001);
        chk("R4 dp1 byte", src_word, 1'b0);
        chk("R7 dp1 valid", src_valid, 1'b1);
    endtask

    task automatic t_ptr_writes();
        logic [15:0] v;
        do_reset();
        wr(1, 3'd2, 16'h1234, 0, 2'd0, 16'h0);
        rd(3'd0, v); chk("R6 dp1 sel", v, 16'h001D);
        chk("R2 dp1 addr", src_addr, 16'h1234);
        wr(1, 3'd3, 16'hFFF0, 0, 2'd0, 16'h0);
        rd(3'd0, v); chk("R6 bp sel", v, 16'h001E);
        wr(1, 3'd1, 16'h0042, 0, 2'd0, 16'h0);
        rd(3'd0, v); chk("R6 dp0 sel", v, 16'h001C);
        chk("R2 dp0 addr", src_addr, 16'h0042);
        chk("R7 dp0 written", src_valid, 1'b1);
        wr(1, 3'd4, 16'h01AB, 0, 2'd0, 16'h0);
        rd(3'd0, v); chk("R6 ofs sel", v, 16'h001E);
        rd(3'd4, v); chk("R10 ofs zext", v, 16'h00AB);
        chk("R8 wrap", src_addr, 16'h009B);
        rd(3'd7, v); chk("R10 unmapped", v, 16'h0000);
    endtask

    task automatic t_arm();
        logic [15:0] v;
        do_reset();
        wr(1, 3'd2, 16'h0500, 0, 2'd0, 16'h0);
        wr(1, 3'd0, 16'h001D, 0, 2'd0, 16'h0);
        wr(1, 3'd0, 16'h0018, 0, 2'd0, 16'h0);
        chk("R7 explicit 00 arms", src_valid, 1'b1);
        chk("R4 dp0 byte", src_word, 1'b0);
        do_reset();
        wr(1, 3'd2, 16'h0500, 0, 2'd0, 16'h0);
        chk("R7 dp1 valid", src_valid, 1'b1);
        wr(1, 3'd0, 16'h001C, 0, 2'd0, 16'h0);
        chk("R7 explicit 00 from dp1", src_valid, 1'b1);
        rd(3'd0, v); chk("R10 ctrl write", v, 16'h001C);
    endtask

    task automatic t_reserved_sel();
        logic [15:0] v;
        do_reset();
        wr(1, 3'd3, 16'h2000, 0, 2'd0, 16'h0);
        wr(1, 3'd4, 16'h0010, 0, 2'd0, 16'h0);
        wr(1, 3'd0, 16'h0003, 0, 2'd0, 16'h0);
        rd(3'd0, v); chk("R3 readback", v, 16'h0003);
        chk("R3 addr", src_addr, 16'h2010);
        chk("R3 byte", src_word, 1'b0);
        wr(1, 3'd0, 16'h0013, 0, 2'd0, 16'h0);
        chk("R3 word", src_word, 1'b1);
        chk("R3 valid", src_valid, 1'b1);
        wr(1, 3'd0, 16'h000E, 0, 2'd0, 16'h0);
        chk("R4 fp byte", src_word, 1'b0);
        chk("R2 fp addr", src_addr, 16'h2010);
    endtask

    task automatic t_collision();
        logic [15:0] v;
        do_reset();
        wr(1, 3'd0, 16'h0000, 1, 2'd1, 16'hBEEF);
        rd(3'd0, v); chk("R9 sel from ptr", v, 16'h0001);
        chk("R9 addr", src_addr, 16'hBEEF);
        chk("R9 byte mode", src_word, 1'b0);
        wr(1, 3'd1, 16'h1111, 1, 2'd0, 16'h2222);
        rd(3'd1, v); chk("R11 ld wins", v, 16'h2222);
        wr(1, 3'd2, 16'h3333, 1, 2'd3, 16'h0077);
        rd(3'd0, v); chk("R11 ld leads sel", v, 16'h0002);
        rd(3'd2, v); chk("R11 reg path kept", v, 16'h3333);
    endtask

    initial begin
        #100000;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_reserved_bits();
        t_ptr_writes();
        t_arm();
        t_reserved_sel();
        t_collision();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule